// File: doc/BRIEF.md
# Triangle-Ramped Duty-Cycle PWM Generator

This block drives a single pulse output at a fixed frequency. Its duty cycle walks up from zero to a programmed ceiling and then back down to zero, and it repeats this without end. When the output passes through an external low-pass filter, the result approximates a triangle wave. A period counter counts fine clock ticks from zero to a programmed limit and then wraps. The output is high while the count is below the current compare value. The compare value is revised only at the wrap point, so every pulse finishes with the width it started with.

Software configures the block through a plain write port: one strobe, an address and a data word. The port has no back-pressure and accepts a write on every cycle that the strobe is high. The configuration covers the period limit, the duty ceiling, independent rising and falling step sizes, and independent rising and falling hold counts. The ramp does not run until the key register holds the unlock code. If any other value is written to the key register, the ramp stops and starts again from zero duty.

Top module: `tri_pwm_gen`

## Requirements
- R1: After reset the output is low, the block is locked, and the compare value, direction and hold counter are all zero.
- R2: The block runs only while the key register (address 6, low 4 bits) holds 0xA. With any other value the output stays low and the period counter, compare value, direction flag and hold counter are held at zero. After a new unlock, the ramp therefore restarts at 0% duty.
- R3: While unlocked, the period counter counts from 0 to the active limit P and then wraps to 0, so one period lasts P+1 cycles.
- R4: In each period the output is high for exactly the first C cycles, where C is the compare value for that period.
- R5: The compare value changes only on the last cycle of a period.
- R6: While the direction flag is 0 (rising), a step raises the compare value by the rising step and saturates at the limit L. When a step finds the compare value already at or above L, it sets the flag to 1 and leaves the compare value unchanged.
- R7: While the direction flag is 1 (falling), a step subtracts the falling step if the compare value is larger than that step. Otherwise the step sets the compare value to 0 and the flag back to 0.
- R8: A hold count of H for the current direction means that H period ends are skipped before each step. The hold counter reloads after every step and on every change of direction. A hold count of 0 gives a step at every period end.
- R9: A programmed step size of 0 acts as a step of 1.
- R10: The limit L is the smaller of the programmed ceiling and P+1, so the duty never exceeds 100%.
- R11: The register addresses are: 0 period limit, 1 ceiling, 2 rising step, 3 falling step, 4 rising hold, 5 falling hold, 6 key. A write made during a period first affects the update at the end of that period, and the output in the rest of that period does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one fine tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W+1 | Write data |
| pwm_o | output | 1 | Pulse output |

## Verification
Two functions can land in the same cycle: a configuration write, and the period-end update that consumes that configuration. The bench changes the rising step partway through a period. The scoreboard then expects the old step for every pulse up to that point and the new step from the update that ends that same period. The direction flip can also coincide with a hold reload. In that case the new direction's hold has to start counting on the very next period, and this is judged by comparing the high-cycle count of every period with a reference ramp model.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  typedef enum logic [2:0] {
    A_PERIOD  = 3'd0,
    A_CEIL    = 3'd1,
    A_UPSTEP  = 3'd2,
    A_DNSTEP  = 3'd3,
    A_UPHOLD  = 3'd4,
    A_DNHOLD  = 3'd5,
    A_KEY     = 3'd6
  } reg_addr_e;

  localparam logic [3:0] UNLOCK_CODE = 4'hA;
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
  import tpwm_pkg::*;
#(
  parameter int CW = 12,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW:0]   wr_data,
  output logic [CW-1:0] per_stg,
  output logic [CW:0]   ceil_stg,
  output logic [CW:0]   up_step,
  output logic [CW:0]   dn_step,
  output logic [HW-1:0] up_hold,
  output logic [HW-1:0] dn_hold,
  output logic          unlocked
);
  logic [CW:0] up_raw, dn_raw;
  logic [3:0]  key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_stg  <= '1;
      ceil_stg <= '0;
      up_raw   <= '0;
      dn_raw   <= '0;
      up_hold  <= '0;
      dn_hold  <= '0;
      key_q    <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_PERIOD: per_stg  <= wr_data[CW-1:0];
        A_CEIL:   ceil_stg <= wr_data;
        A_UPSTEP: up_raw   <= wr_data;
        A_DNSTEP: dn_raw   <= wr_data;
        A_UPHOLD: up_hold  <= wr_data[HW-1:0];
        A_DNHOLD: dn_hold  <= wr_data[HW-1:0];
        A_KEY:    key_q    <= wr_data[3:0];
        default:  ;
      endcase
    end
  end

  // zero step is promoted to one fine unit
  assign up_step  = (up_raw == '0) ? (CW+1)'(1) : up_raw;
  assign dn_step  = (dn_raw == '0) ? (CW+1)'(1) : dn_raw;
  assign unlocked = (key_q == UNLOCK_CODE);
endmodule

// File: rtl/tpwm_period.sv
module tpwm_period #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlocked,
  input  logic [CW-1:0] per_stg,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_act,
  output logic          term
);
  assign term = unlocked && (cnt == per_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= '1;
    end else if (!unlocked || term) begin
      cnt     <= '0;
      per_act <= per_stg;
    end else begin
      cnt     <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tpwm_ramp.sv
module tpwm_ramp #(
  parameter int CW = 12,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlocked,
  input  logic          term,
  input  logic [CW-1:0] per_stg,
  input  logic [CW:0]   ceil_stg,
  input  logic [CW:0]   up_step,
  input  logic [CW:0]   dn_step,
  input  logic [HW-1:0] up_hold,
  input  logic [HW-1:0] dn_hold,
  output logic [CW:0]   cmp,
  output logic          dir
);
  logic [HW-1:0] hold;
  logic [CW:0]   per_top, lim;
  logic [CW+1:0] sum;

  assign per_top = {1'b0, per_stg} + (CW+1)'(1);
  assign lim     = (ceil_stg > per_top) ? per_top : ceil_stg;
  assign sum     = {1'b0, cmp} + {1'b0, up_step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      dir  <= 1'b0;
      hold <= '0;
    end else if (!unlocked) begin
      cmp  <= '0;
      dir  <= 1'b0;
      hold <= '0;
    end else if (term) begin
      if (hold != '0) begin
        hold <= hold - HW'(1);
      end else if (!dir) begin
        if (cmp < lim) begin
          cmp  <= (sum >= {1'b0, lim}) ? lim : sum[CW:0];
          hold <= up_hold;
        end else begin
          dir  <= 1'b1;
          hold <= dn_hold;
        end
      end else begin
        if (cmp > dn_step) begin
          cmp  <= cmp - dn_step;
          hold <= dn_hold;
        end else begin
          cmp  <= '0;
          dir  <= 1'b0;
          hold <= up_hold;
        end
      end
    end
  end
endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen #(
  parameter int CNT_W  = 12,
  parameter int HOLD_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [CNT_W:0] wr_data,
  output logic           pwm_o
);
  logic [CNT_W-1:0]  per_stg, per_act, cnt;
  logic [CNT_W:0]    ceil_stg, up_step, dn_step, cmp;
  logic [HOLD_W-1:0] up_hold, dn_hold;
  logic              unlocked, term, dir;

  tpwm_regs #(.CW(CNT_W), .HW(HOLD_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .per_stg, .ceil_stg, .up_step, .dn_step, .up_hold, .dn_hold, .unlocked
  );

  tpwm_period #(.CW(CNT_W)) u_period (
    .clk, .rst_n, .unlocked, .per_stg, .cnt, .per_act, .term
  );

  tpwm_ramp #(.CW(CNT_W), .HW(HOLD_W)) u_ramp (
    .clk, .rst_n, .unlocked, .term, .per_stg, .ceil_stg,
    .up_step, .dn_step, .up_hold, .dn_hold, .cmp, .dir
  );

  assign pwm_o = unlocked && ({1'b0, cnt} < cmp);
endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm,
  input logic          unlocked,
  input logic          term,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per,
  input logic [CW:0]   cmp,
  input logic          dir
);
  AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !pwm); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> (cnt <= per)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (cnt == '0)); // R3
  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !term) |=> $stable(cmp)); // R5
  AST_FLIP_DOWN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir) |-> $stable(cmp)); // R6
  AST_FLIP_UP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir) |-> (cmp == '0)); // R7
endmodule

bind tri_pwm_gen tpwm_checker #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm(pwm_o), .unlocked(unlocked), .term(term),
  .cnt(cnt), .per(per_act), .cmp(cmp), .dir(dir)
);

// File: tb/test_tri_pwm_gen.sv
module test_tri_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int HW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [CW:0] wr_data = '0;
  logic        pwm_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_pwm_gen #(.CNT_W(CW), .HOLD_W(HW)) i_tri_pwm_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  typedef struct { int exp; string tag; } item_t;
  item_t sb_q[$];

  int checks = 0, fails = 0;
  bit run = 0, done = 0;
  int samp = 0, acc = 0, win = 0;
  bit seen_low = 0, reorder = 0;
  int per_cfg = 9;

  // reference ramp model
  int m_per, m_ceil, m_up, m_dn, m_hu, m_hd;
  int m_cmp, m_dir, m_hold;

  function automatic int mdl_lim();
    int t;
    t = m_per + 1;
    return (m_ceil > t) ? t : m_ceil;
  endfunction

  function automatic void mdl_tick();
    int st, l;
    if (m_hold != 0) m_hold--;
    else if (m_dir == 0) begin
      st = (m_up == 0) ? 1 : m_up;
      l  = mdl_lim();
      if (m_cmp < l) begin
        m_cmp  = (m_cmp + st >= l) ? l : m_cmp + st;
        m_hold = m_hu;
      end else begin
        m_dir = 1; m_hold = m_hd;
      end
    end else begin
      st = (m_dn == 0) ? 1 : m_dn;
      if (m_cmp > st) begin
        m_cmp -= st; m_hold = m_hd;
      end else begin
        m_cmp = 0; m_dir = 0; m_hold = m_hu;
      end
    end
  endfunction

  task automatic push_run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      sb_q.push_back('{m_cmp, tag});
      mdl_tick();
    end
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = (CW+1)'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic cfg(int per, int ceil, int up, int dn, int hu, int hd);
    wr(0, per); wr(1, ceil); wr(2, up); wr(3, dn); wr(4, hu); wr(5, hd);
    m_per = per; m_ceil = ceil; m_up = up; m_dn = dn; m_hu = hu; m_hd = hd;
    per_cfg = per;
    m_cmp = 0; m_dir = 0; m_hold = 0;
  endtask

  task automatic drain_and_lock();
    while (sb_q.size() != 0) @(posedge clk);
    #1 run = 0;
    wr(6, 0);
  endtask

  // monitor: one window per period, count high cycles, pop and compare
  always @(negedge clk) begin
    if (!run) begin
      samp = 0; acc = 0; win = 0; seen_low = 0; reorder = 0;
    end else begin
      if (pwm_o) begin
        if (seen_low) reorder = 1;
        acc++;
      end else seen_low = 1;
      samp++;
      if (samp == per_cfg + 1) begin
        if (sb_q.size() != 0) begin
          item_t it;
          it = sb_q.pop_front();
          checks++;
          if (acc != it.exp || reorder) begin
            fails++;
            $display("FAIL %s window %0d: high=%0d reorder=%0d expected high=%0d",
                     it.tag, win, acc, reorder, it.exp);
          end
        end
        samp = 0; acc = 0; seen_low = 0; reorder = 0; win++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++; // R1 reset state
    if (pwm_o !== 1'b0) begin
      fails++; $display("FAIL R1 reset output: actual=%b expected=0", pwm_o);
    end

    // R2: wrong key keeps the block idle
    cfg(9, 7, 3, 2, 0, 1);
    wr(6, 5);
    m_cmp = 0; m_dir = 0; m_hold = 0;
    for (int i = 0; i < 4; i++) sb_q.push_back('{0, "R2"});
    run = 1;
    drain_and_lock();

    // R3 R4 R6 R7 R8: ramp with falling hold
    m_cmp = 0; m_dir = 0; m_hold = 0;
    push_run(16, "R4_R6_R7_R8");
    wr(6, 10); run = 1;
    drain_and_lock();

    // R2: relock then unlock restarts from zero duty
    m_cmp = 0; m_dir = 0; m_hold = 0;
    push_run(5, "R2_restart");
    wr(6, 10); run = 1;
    drain_and_lock();

    // R9 R10: zero step promoted, ceiling clamped to full period
    cfg(9, 30, 0, 4, 0, 0);
    push_run(20, "R9_R10");
    wr(6, 10); run = 1;
    drain_and_lock();

    // R11: rising step rewritten during window 2
    cfg(9, 9, 1, 3, 0, 0);
    push_run(2, "R11");
    sb_q.push_back('{m_cmp, "R11"});
    m_up = 4;
    mdl_tick();
    push_run(8, "R11");
    wr(6, 10); run = 1;
    while (!(win == 2 && samp == 3)) @(posedge clk);
    wr(2, 4);
    drain_and_lock();

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule